// File: doc/BRIEF.md
# Discriminator Pulse-Train Gating Controller

This block is the timing core of one photodetector front-end channel. A rising edge on the discriminator input starts an event when the channel is idle. The event opens two nested windows. The short one passes the raw discriminator level to the channel output as time-over-threshold (TOT) pulses. The long one drives the integration gate of an external charge-to-time converter and the channel trigger.

When the long window closes, a latch raises the charge pulse. The latch holds it for as long as the converter's time output stays high, so the length of the charge pulse encodes the integrated charge. The channel output is one pulse train per event: the TOT pulses, a quiet gap of `GATE_CYC - TOT_CYC` cycles, then the charge pulse.

No new event starts while any part of the current one is in progress, or while the converter's time output is high. All inputs are synchronous single-bit levels. Window lengths are given in clock cycles. The defaults, 40 and 45 cycles at 200 MHz, correspond to windows of about 200 ns and 225 ns.

Top module: `pulse_gate_ctrl`

## Requirements
- R1: A rising edge of `disc_i` is an accepted trigger when four conditions hold in its cycle: `gate_o` is low, `charge_o` is low, `qtime_i` is low and `rst` is low. `gate_o` and `trig_o` then go high in the next cycle.
- R2: For the first `TOT_CYC` cycles after an accepted trigger, `train_o` equals `disc_i` in the same cycle.
- R3: After an accepted trigger, `gate_o` and `trig_o` stay high for exactly `GATE_CYC` consecutive cycles and then go low.
- R4: In cycles `TOT_CYC+1` to `GATE_CYC` after an accepted trigger, `train_o` is low whatever `disc_i` does.
- R5: `charge_o` goes high in the first cycle after `gate_o` falls.
- R6: Once high, `charge_o` stays high while `qtime_i` is high. It goes low in the cycle after `qtime_i` is sampled low. If `qtime_i` is already low when the gate closes, `charge_o` is high for exactly one cycle.
- R7: Outside both windows, `train_o` equals `charge_o`.
- R8: No trigger is accepted while `qtime_i` is high: `gate_o` stays low in the following cycle.
- R9: A rising edge of `disc_i` while `gate_o` or `charge_o` is high neither restarts nor extends the event.
- R10: `rst` is synchronous and active high. It clears all event state, and all four outputs are low in every cycle in which it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| disc_i | input | 1 | Discriminator level |
| qtime_i | input | 1 | Time output of the charge-to-time converter |
| gate_o | output | 1 | Integration gate to the converter |
| trig_o | output | 1 | Channel trigger, high for the gate window |
| charge_o | output | 1 | Latched charge pulse |
| train_o | output | 1 | Combined pulse train: gated TOT pulses OR charge pulse |

## Verification
The bench sweeps disc_i patterns of several densities against converter responses of every length from zero up past the gate, with and without stray converter activity. This covers the following faults:
- An off-by-one in the window counter would shift the gate fall or the end of the TOT window by one cycle. It would also merge the quiet gap into the TOT pulses or the charge pulse.
- A latch that gave priority to clear over set would lose the one-cycle charge pulse when the converter never responds.
- A trigger arm that ignored the converter or the latch would restart the gate in the middle of an event.
- Reset applied during an event would leave either the windows or the latch live.

// File: rtl/pgc_pkg.sv
package pgc_pkg;

   // Window status decoded from the shared event counter.
   typedef struct packed {
      logic tot;   // TOT window open
      logic gate;  // gate window open
      logic last;  // final cycle of the gate window
   } pgc_win_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/pgc_edge_det.sv
module pgc_edge_det (
   input  logic clk,
   input  logic rst,
   input  logic lvl_i,
   output logic rise_o
);
   logic lvl_q;

   always_ff @(posedge clk) begin
      if (rst) lvl_q <= 1'b0;
      else     lvl_q <= lvl_i;
   end

   assign rise_o = lvl_i & ~lvl_q;
endmodule

// File: rtl/pgc_window.sv
module pgc_window
   import pgc_pkg::*;
#(
   parameter int unsigned TOT_CYC  = 40,
   parameter int unsigned GATE_CYC = 45,
   parameter int unsigned CW       = 6
) (
   input  logic     clk,
   input  logic     rst,
   input  logic     start_i,
   output pgc_win_t win_o
);
   localparam logic [CW-1:0] LOAD_V   = CW'(GATE_CYC);
   localparam logic [CW-1:0] TOT_FLOOR = CW'(GATE_CYC - TOT_CYC);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                  cnt_q <= '0;
      else if (start_i)         cnt_q <= LOAD_V;
      else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
   end

   // Counter runs GATE_CYC..1; the TOT window is its top TOT_CYC values.
   assign win_o.gate = (cnt_q != '0);
   assign win_o.tot  = (cnt_q > TOT_FLOOR);
   assign win_o.last = (cnt_q == CW'(1));
endmodule

// File: rtl/pgc_charge_latch.sv
module pgc_charge_latch (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic hold_i,
   output logic q_o
);
   logic q_q;

   // Set has priority so a silent converter still yields one cycle.
   always_ff @(posedge clk) begin
      if (rst)              q_q <= 1'b0;
      else if (set_i)       q_q <= 1'b1;
      else if (!hold_i)     q_q <= 1'b0;
   end

   assign q_o = q_q;
endmodule

// File: rtl/pulse_gate_ctrl.sv
module pulse_gate_ctrl
   import pgc_pkg::*;
#(
   parameter int unsigned TOT_CYC   = 40,
   parameter int unsigned GATE_CYC  = 45,
   parameter bit          REG_TRAIN = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic disc_i,
   input  logic qtime_i,
   output logic gate_o,
   output logic trig_o,
   output logic charge_o,
   output logic train_o
);
   localparam int unsigned CW = cnt_width(GATE_CYC);

   if (TOT_CYC < 1 || GATE_CYC <= TOT_CYC) begin : g_bad_cfg
      initial $fatal(1, "pulse_gate_ctrl: need 1 <= TOT_CYC < GATE_CYC");
   end

   logic     disc_rise;
   logic     arm;
   logic     fire;
   logic     charge_q;
   logic     train_comb;
   pgc_win_t win;

   pgc_edge_det u_edge (
      .clk    (clk),
      .rst    (rst),
      .lvl_i  (disc_i),
      .rise_o (disc_rise)
   );

   assign arm  = ~win.gate & ~charge_q & ~qtime_i;
   assign fire = disc_rise & arm;

   pgc_window #(
      .TOT_CYC  (TOT_CYC),
      .GATE_CYC (GATE_CYC),
      .CW       (CW)
   ) u_win (
      .clk     (clk),
      .rst     (rst),
      .start_i (fire),
      .win_o   (win)
   );

   pgc_charge_latch u_chg (
      .clk    (clk),
      .rst    (rst),
      .set_i  (win.last),
      .hold_i (qtime_i),
      .q_o    (charge_q)
   );

   assign train_comb = (win.tot & disc_i) | charge_q;

   if (REG_TRAIN) begin : g_train_reg
      logic train_q;
      always_ff @(posedge clk) begin
         if (rst) train_q <= 1'b0;
         else     train_q <= train_comb;
      end
      assign train_o = train_q & ~rst;
   end else begin : g_train_comb
      assign train_o = train_comb & ~rst;
   end

   assign gate_o   = win.gate & ~rst;
   assign trig_o   = win.gate & ~rst;
   assign charge_o = charge_q & ~rst;
endmodule

// File: rtl/pgc_checker.sv
module pgc_checker #(
   parameter int unsigned GATE_CYC = 45
) (
   input logic clk,
   input logic rst,
   input logic disc_i,
   input logic qtime_i,
   input logic gate_o,
   input logic trig_o,
   input logic charge_o,
   input logic train_o
);
   logic [31:0] trig_run;

   always_ff @(posedge clk) begin
      if (rst)         trig_run <= '0;
      else if (trig_o) trig_run <= trig_run + 1;
      else             trig_run <= '0;
   end

   // R1: an armed rising edge opens the gate next cycle
   p_rise_opens_r1: assert property (@(posedge clk) disable iff (rst)
      ($rose(disc_i) && !gate_o && !charge_o && !qtime_i) |=> gate_o);

   // R3: trigger window lasts exactly GATE_CYC cycles
   p_trig_len_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(trig_o) |-> (trig_run == 32'(GATE_CYC)));

   // R5: charge pulse starts right after the gate closes
   p_charge_after_gate_r5: assert property (@(posedge clk) disable iff (rst)
      $fell(gate_o) |-> charge_o);

   // R6: charge pulse held while converter time output is high
   p_charge_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (charge_o && qtime_i) |=> charge_o);

   // R7: outside the event the train carries nothing but the charge pulse
   p_train_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      (!gate_o && !charge_o) |-> !train_o);

   // R8: no trigger while the converter is busy
   p_no_trig_busy_r8: assert property (@(posedge clk) disable iff (rst)
      (!gate_o && qtime_i) |=> !gate_o);
endmodule

bind pulse_gate_ctrl pgc_checker #(.GATE_CYC(GATE_CYC)) u_pgc_chk (
   .clk      (clk),
   .rst      (rst),
   .disc_i   (disc_i),
   .qtime_i  (qtime_i),
   .gate_o   (gate_o),
   .trig_o   (trig_o),
   .charge_o (charge_o),
   .train_o  (train_o)
);

// File: tb/pulse_gate_ctrl_tb.sv
module pulse_gate_ctrl_tb_top;
   localparam int TOT  = 4;
   localparam int GATE = 7;
   localparam int QD   = 2;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic disc_i = 1'b0;
   logic qtime_i = 1'b0;
   logic gate_o, trig_o, charge_o, train_o;

   int checks = 0;
   int errors = 0;

   // reference state
   int cyc = 0;
   int tf  = -1000;
   bit chg_m = 1'b0;
   bit dprev_m = 1'b0;
   logic [15:0] lf = 16'hACE1;

   always #2 clk = ~clk;

   pulse_gate_ctrl #(.TOT_CYC(TOT), .GATE_CYC(GATE), .REG_TRAIN(1'b0)) dut_i (
      .clk      (clk),
      .rst      (rst),
      .disc_i   (disc_i),
      .qtime_i  (qtime_i),
      .gate_o   (gate_o),
      .trig_o   (trig_o),
      .charge_o (charge_o),
      .train_o  (train_o)
   );

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s cycle %0d actual %0b expected %0b", tag, what, cyc, act, exp);
      end
   endtask

   task automatic model_reset();
      tf = -1000; chg_m = 1'b0; dprev_m = 1'b0;
   endtask

   // One clock cycle: drive, compare in the low phase, advance the model.
   task automatic step(input bit d, input bit q, input string tag);
      int k;
      bit w1, w2, fire;
      string tg, tc, tt;
      @(posedge clk); #1;
      disc_i = d; qtime_i = q;
      @(negedge clk);
      k  = cyc - tf;
      w1 = (k >= 1) && (k <= TOT);
      w2 = (k >= 1) && (k <= GATE);
      tg = (tag != "") ? tag : "R3";
      tc = (tag != "") ? tag : ((k == GATE + 1) ? "R5" : "R6");
      tt = (tag != "") ? tag : (w1 ? "R2" : (w2 ? "R4" : "R7"));
      chk(tg, "gate_o",   gate_o,   w2);
      chk(tg, "trig_o",   trig_o,   w2);
      chk(tc, "charge_o", charge_o, chg_m);
      chk(tt, "train_o",  train_o,  (w1 && d) || chg_m);
      fire = d && !dprev_m && !w2 && !chg_m && !q;
      if (k == GATE)          chg_m = 1'b1;
      else if (chg_m && !q)   chg_m = 1'b0;
      if (fire) tf = cyc;
      dprev_m = d;
      cyc++;
   endtask

   task automatic do_reset(input int n);
      rst = 1'b1; disc_i = 1'b1; qtime_i = 1'b1;
      for (int i = 0; i < n; i++) begin
         @(posedge clk); #1;
         @(negedge clk);
         chk("R10", "gate_o",   gate_o,   1'b0);
         chk("R10", "trig_o",   trig_o,   1'b0);
         chk("R10", "charge_o", charge_o, 1'b0);
         chk("R10", "train_o",  train_o,  1'b0);
      end
      @(posedge clk); #1;
      rst = 1'b0; disc_i = 1'b0; qtime_i = 1'b0;
      model_reset();
   endtask

   initial begin
      #(4 * 200000);
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #1;
      chk("R10", "gate_o at start",  gate_o,  1'b0);
      chk("R10", "train_o at start", train_o, 1'b0);
      do_reset(3);

      // R1 accepted trigger, then R9 edges during the event, silent converter
      step(0, 0, "R1");
      step(1, 0, "R1");
      step(1, 0, "R1");
      for (int i = 0; i < GATE + 4; i++) step(i % 2, 0, "R9");
      for (int i = 0; i < 3; i++) step(0, 0, "R6");

      // R8: converter busy blocks the trigger
      step(0, 1, "R8");
      step(1, 1, "R8");
      step(1, 1, "R8");
      step(0, 0, "R8");
      step(0, 0, "R8");

      // R10: reset in the middle of an event
      step(1, 0, "R10");
      step(0, 0, "R10");
      step(1, 0, "R10");
      do_reset(2);
      step(0, 0, "R10");
      step(0, 0, "R10");

      // sweep: converter response length x discriminator density x stray activity
      for (int stray = 0; stray < 2; stray++) begin
         for (int dens = 2; dens <= 14; dens += 4) begin
            for (int qlen = 0; qlen <= 12; qlen++) begin
               for (int n = 0; n < 60; n++) begin
                  int k;
                  bit d, q;
                  lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
                  d = (int'(lf[3:0]) < dens);
                  k = cyc - tf;
                  q = (k >= QD + 1) && (k <= QD + qlen);
                  if (stray != 0 && (cyc % 23) < 3) q = 1'b1;
                  step(d, q, "");
               end
            end
         end
      end

      do_reset(1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule